// File: doc/BRIEF.md
# Legacy Memory Window Address Decoder

This block sits between a real-mode address generator and the memories behind it. Each request carries a 20-bit address, an access size, a read/write flag and write data. The decoder chooses which target serves the request and how far into that target the access lands. The targets are:

- a shadow copy of the option ROM;
- a video frame-buffer window;
- a tiny constant ROM holding the machine identity bytes;
- main RAM.

The answer is registered and appears one clock after the request.

Two configuration inputs shape the map: the last address of the option-ROM image and the size of main RAM. Option-ROM addresses past the configured limit, up to the fixed 0xD0000 boundary, are treated as suspicious and are redirected to the start of RAM. Any address that no region claims and that lies beyond the RAM size is also redirected to the start of RAM, and it raises a halt flag that stays set until reset. A blanking switch turns the video window into a sink: reads there give zero and writes are dropped. The identity ROM is served inside the block itself, so its read data comes back with the response.

Top module: `legacy_window_decoder`

## Requirements
- R1: For an address `a` with 0xC0000 <= `a` <= `cfg_rom_limit`, the response has target code 1 (option ROM) and offset `a` - 0xC0000. This region is decoded ahead of every other region.
- R2: For `cfg_rom_limit` < `a` < 0xD0000, the response has target code 0 (RAM), offset 0 and `rsp_suspicious` = 1. `rsp_suspicious` is 0 for every other address.
- R3: With `video_blank` = 0, an address from 0xA0000 to 0xBFFFF gives target code 2 (video) and offset `a` - 0xA0000.
- R4: With `video_blank` = 1, an address from 0xA0000 to 0xBFFFF gives target code 4 (none), offset 0, `rsp_rdata` = 0 and `rsp_write` = 0.
- R5: An address from 0xFFFF5 to 0xFFFFF gives target code 3 (identity ROM) and offset `a` - 0xFFFF5. It never forwards a write.
- R6: The identity ROM bytes are as follows. Addresses 0xFFFF5 to 0xFFFFC hold the ASCII characters "08/14/99" in ascending order, 0xFFFFD holds 0x00, 0xFFFFE holds 0xFC and 0xFFFFF holds 0x00. `rsp_rdata` packs the bytes at `a`, `a`+1, and so on, little-endian (the byte at `a` in bits 7:0). A byte past 0xFFFFF reads as 0.
- R7: Size code 0 selects a byte, 1 a word, and 2 or 3 a dword. `rsp_rdata` and `rsp_wdata` carry zeros above the selected size. `rsp_wdata` is `req_wdata` under that mask.
- R8: Any other address with `a` >= `cfg_ram_size` gives target code 0 and offset 0, and sets `halted`. `halted` stays 1 until reset.
- R9: Any remaining address gives target code 0 and offset `a`. For targets 0, 1 and 2, `rsp_write` equals `req_write`. `rsp_rdata` is 0 for every target other than 3.
- R10: After reset, `rsp_valid` and `halted` are 0. The response to a request presented at one rising edge is valid at the next edge only, and `rsp_valid` is 0 when there was no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rom_limit | input | 20 | Last address of the option-ROM image |
| cfg_ram_size | input | 21 | Main RAM size in bytes (up to 0x100000) |
| video_blank | input | 1 | 1 turns the video window into a zero-read, write-dropping sink |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 20 | Request address |
| req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| req_write | input | 1 | 1 for a write |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_target | output | 3 | 0 RAM, 1 option ROM, 2 video, 3 identity ROM, 4 none |
| rsp_offset | output | 20 | Offset inside the selected target |
| rsp_size | output | 2 | Registered request size |
| rsp_write | output | 1 | Write forwarded to the target |
| rsp_wdata | output | 32 | Write data masked to the size |
| rsp_rdata | output | 32 | Read data for the identity ROM and the blanked window, else 0 |
| rsp_suspicious | output | 1 | Access fell into the gap above the option-ROM limit |
| halted | output | 1 | Sticky out-of-range flag |

## Verification
The assertions assume that the configuration inputs stay steady while requests flow and change only around a reset. They also assume that `cfg_rom_limit` lies between 0xC0000 and 0xCFFFF, so the option-ROM region and the guard gap never overlap the video window or the identity ROM. The stimulus keeps to this. Each configuration is loaded, the block is reset, and only then does a sweep start. The sweeps step through the whole 1 MB space and probe every region boundary with all three sizes.

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_rom_limit,
  input  logic [AW:0]   cfg_ram_size,
  input  logic          video_blank,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [2:0]    rsp_target,
  output logic [AW-1:0] rsp_offset,
  output logic [1:0]    rsp_size,
  output logic          rsp_write,
  output logic [DW-1:0] rsp_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_suspicious,
  output logic          halted
);
  localparam int NB = DW / 8;
  localparam logic [AW-1:0] ROM_BASE = 20'hC0000;
  localparam logic [AW-1:0] GAP_END  = 20'hD0000;
  localparam logic [AW-1:0] VID_BASE = 20'hA0000;
  localparam logic [AW-1:0] VID_LAST = 20'hBFFFF;
  localparam logic [AW-1:0] ID_BASE  = 20'hFFFF5;
  localparam logic [2:0] T_RAM = 3'd0, T_ROM = 3'd1, T_VID = 3'd2, T_ID = 3'd3, T_NONE = 3'd4;

  function automatic logic [7:0] id_byte(input logic [AW:0] a);
    if (a[AW:4] != {1'b0, 16'hFFFF}) return 8'h00;
    case (a[3:0])
      4'h5: return 8'h30;
      4'h6: return 8'h38;
      4'h7: return 8'h2F;
      4'h8: return 8'h31;
      4'h9: return 8'h34;
      4'hA: return 8'h2F;
      4'hB: return 8'h39;
      4'hC: return 8'h39;
      4'hE: return 8'hFC;
      default: return 8'h00;
    endcase
  endfunction

  logic [DW-1:0] mask, id_word, d_rdata;
  logic [2:0]    d_target;
  logic [AW-1:0] d_offset;
  logic          d_susp, d_halt;

  assign mask = (req_size == 2'd0) ? DW'(8'hFF) :
                (req_size == 2'd1) ? DW'(16'hFFFF) : '1;

  always_comb begin
    id_word = '0;
    for (int i = 0; i < NB; i++)
      id_word[8*i +: 8] = id_byte({1'b0, req_addr} + (AW+1)'(i));
  end

  always_comb begin
    d_target = T_RAM;
    d_offset = req_addr;
    d_susp   = 1'b0;
    d_halt   = 1'b0;
    d_rdata  = '0;
    if (req_addr >= ROM_BASE && req_addr <= cfg_rom_limit) begin
      d_target = T_ROM;
      d_offset = req_addr - ROM_BASE;
    end else if (req_addr > cfg_rom_limit && req_addr < GAP_END) begin
      d_offset = '0;
      d_susp   = 1'b1;
    end else if (req_addr >= VID_BASE && req_addr <= VID_LAST) begin
      d_target = video_blank ? T_NONE : T_VID;
      d_offset = video_blank ? '0 : req_addr - VID_BASE;
    end else if (req_addr >= ID_BASE) begin
      d_target = T_ID;
      d_offset = req_addr - ID_BASE;
      d_rdata  = id_word & mask;
    end else if ({1'b0, req_addr} >= cfg_ram_size) begin
      d_offset = '0;
      d_halt   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_target     <= T_RAM;
      rsp_offset     <= '0;
      rsp_size       <= '0;
      rsp_write      <= 1'b0;
      rsp_wdata      <= '0;
      rsp_rdata      <= '0;
      rsp_suspicious <= 1'b0;
      halted         <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_target     <= d_target;
        rsp_offset     <= d_offset;
        rsp_size       <= req_size;
        rsp_write      <= req_write && (d_target <= T_VID);
        rsp_wdata      <= req_wdata & mask;
        rsp_rdata      <= d_rdata;
        rsp_suspicious <= d_susp;
        if (d_halt) halted <= 1'b1;
      end
    end
  end

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_gap_to_ram_base: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_suspicious |-> rsp_target == T_RAM && rsp_offset == '0);
  a_r4_blank_sink: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_target == T_NONE |-> !rsp_write && rsp_rdata == '0);
  a_r5_id_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_target == T_ID |-> !rsp_write);
  a_r1_rom_in_image: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= ROM_BASE && req_addr <= cfg_rom_limit |=>
      rsp_target == T_ROM && rsp_offset == $past(req_addr) - ROM_BASE);
endmodule

// File: tb/legacy_window_decoder_test.sv
module legacy_window_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [19:0] cfg_rom_limit = 20'hC7FFF;
  logic [20:0] cfg_ram_size = 21'h80000;
  logic video_blank = 0, req_valid = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_write, rsp_suspicious, halted;
  logic [2:0] rsp_target;
  logic [19:0] rsp_offset;
  logic [1:0] rsp_size;
  logic [31:0] rsp_wdata, rsp_rdata;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0, exp_halt = 0;

  always #2 clk = ~clk;

  legacy_window_decoder uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(int unsigned a);
    string s = "08/14/99";
    if (a >= 'hFFFF5 && a <= 'hFFFFC) return s[a - 'hFFFF5];
    if (a == 'hFFFFE) return 8'hFC;
    return 8'h00;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; exp_halt = 0;
    check("R10 reset rsp_valid", rsp_valid, 0);
    check("R10 reset halted", halted, 0);
  endtask

  task automatic access(int unsigned a, int sz, bit wr, logic [31:0] wd);
    int unsigned t, off, lim, ram;
    bit susp, hit;
    logic [31:0] m, rd;
    string tag;
    lim = cfg_rom_limit; ram = cfg_ram_size;
    m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF;
    rd = 0; susp = 0; hit = 0;
    if (a >= 'hC0000 && a <= lim) begin t = 1; off = a - 'hC0000; tag = "R1"; end
    else if (a > lim && a < 'hD0000) begin t = 0; off = 0; susp = 1; tag = "R2"; end
    else if (a >= 'hA0000 && a <= 'hBFFFF) begin
      if (video_blank) begin t = 4; off = 0; tag = "R4"; end
      else begin t = 2; off = a - 'hA0000; tag = "R3"; end
    end else if (a >= 'hFFFF5) begin
      t = 3; off = a - 'hFFFF5; tag = "R5";
      for (int i = 0; i < 4; i++) rd[8*i +: 8] = ref_byte(a + i);
      rd &= m;
    end else if (a >= ram) begin t = 0; off = 0; hit = 1; tag = "R8"; end
    else begin t = 0; off = a; tag = "R9"; end
    @(negedge clk);
    req_valid = 1; req_addr = a[19:0]; req_size = sz[1:0]; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (hit) exp_halt = 1;
    check({tag, " R10 valid"}, rsp_valid, 1);
    check({tag, " target"}, rsp_target, t);
    check({tag, " offset"}, rsp_offset, off);
    check("R2 suspicious", rsp_suspicious, susp);
    check({tag, " R6 rdata"}, rsp_rdata, rd);
    check("R7 wdata mask", rsp_wdata, wd & m);
    check({tag, " R9 write fwd"}, rsp_write, wr && t <= 2);
    check("R8 halted", halted, exp_halt);
    @(negedge clk);
    check("R10 idle", rsp_valid, 0);
  endtask

  task automatic edges();
    int unsigned e[] = '{'h0, 'h7FFFF, 'h80000, 'h9FFFF, 'hA0000, 'hBFFFF, 'hC0000,
                         'hC7FFF, 'hC8000, 'hCBFFF, 'hCC000, 'hCFFFF, 'hD0000, 'hFFFF4};
    foreach (e[k]) for (int s = 0; s < 3; s++) access(e[k], s, s[0], 32'hA5C3_1E7F);
    for (int a = 'hFFFF5; a <= 'hFFFFF; a++)
      for (int s = 0; s < 4; s++) access(a, s, s == 3, 32'h1234_5678);
  endtask

  initial begin
    cfg_rom_limit = 20'hCBFFF; cfg_ram_size = 21'h100000; video_blank = 0;
    do_reset();
    edges();
    for (int a = 0; a < 'h100000; a += 'h1000) access(a + 'h7FF, a[13:12], a[12], a);
    video_blank = 1;
    do_reset();
    edges();
    for (int a = 'hA0000; a < 'hC0000; a += 'h400) access(a, 2, a[10], 32'hFFFF_FFFF);
    cfg_rom_limit = 20'hC7FFF; cfg_ram_size = 21'h80000; video_blank = 0;
    do_reset();
    access('h7FFFF, 0, 1, 32'h11);
    edges();
    for (int a = 0; a < 'h100000; a += 'h800) access(a, a[12:11], a[11], ~a);
    do_reset();
    check("R8 halt cleared by reset", halted, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule